// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a small multicycle processor with one accumulator. It holds a program counter, a memory address register, a memory data register, an instruction register and the accumulator. A word memory sits inside the block. Every instruction passes through the same fixed walk of register transfers. The walk fetches the instruction word, decodes it, fetches the operand and executes the operation. It then advances the program counter and starts the next instruction. Only the execute step differs from one opcode to another: it loads the accumulator, stores the accumulator or adds to it.

The memory is single-ported. Its array read is captured into the data register on a clock edge, so the sequencer spends a wait cycle before each step that uses fetched data. An instruction word has a 4-bit opcode in bits 15:12 and a 12-bit address in bits 11:0. A halt opcode parks the sequencer.

A host port can load and inspect the memory. It is used while the block is held in reset or after it has halted, so a program can be placed in memory and its results read back.

Top module: `acc_seq_cpu`

## Requirements
- R1: After reset ends, each instruction takes exactly 7 clock cycles. The steps run in this order: address from PC, fetch wait, IR load, address from IR field, operand wait, execute, PC increment. When the first halt sits at word n, `halted` first reads 1 on the 7n+6th rising edge after `rst_n` is released, counting the two reset-release edges.
- R2: Bits 15:12 of an instruction word are the opcode and bits 11:0 are the address. The address selects memory word (address mod 256). The upper address bits only take part in that modulo.
- R3: Opcode 0x0 (load) sets the accumulator to the addressed memory word.
- R4: Opcode 0x1 (store) writes the accumulator into the addressed memory word and leaves the accumulator unchanged.
- R5: Opcode 0x2 (add) sets the accumulator to the accumulator plus the addressed word, modulo 2^16, and raises no flag.
- R6: Opcode 0xF (halt) drives `halted` high and keeps it high. From then on PC stays at the address of the halt word, and the accumulator and memory stay unchanged.
- R7: Any other opcode changes neither the accumulator nor the memory. It still takes the full 7 cycles and advances PC.
- R8: While `rst_n` is low, `pc_out` and `acc_out` read 0 and `halted` reads 0.
- R9: While `host_en` is high, the memory is addressed by `host_addr`. A write of `host_wdata` happens on a rising edge when `host_we` is high. `host_rdata` shows the addressed word without delay.
- R10: PC changes only by +1, once per completed non-halt instruction. Execution starts at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| host_en | input | 1 | Host takes the memory port |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host word address (mod 256) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Memory word at the current address |
| halted | output | 1 | Sequencer parked on a halt opcode |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |

## Verification
On every cycle, the assertions check the order of the sequencer steps and that the halt state holds. They also check that the program counter moves only by one and that the accumulator changes only after an execute-step load or add. The arithmetic results can only be shown by the bench's scenarios, which run random and directed programs. These cover the 16-bit wrap of the add and the memory contents left by stores. They also cover the ignored opcodes, the modulo folding of address fields and the exact 7n+6 cycle count to halt.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h1;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR = 3'd0,
    ST_FETCH_WAIT = 3'd1,
    ST_DECODE     = 3'd2,
    ST_OPER_ADDR  = 3'd3,
    ST_OPER_WAIT  = 3'd4,
    ST_EXEC       = 3'd5,
    ST_INCR       = 3'd6,
    ST_HALT       = 3'd7
  } step_e;

  // One-hot style register-transfer strobes from sequencer to datapath
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_load;
    logic acc_load;
    logic acc_add;
    logic mem_we;
    logic pc_inc;
  } xfer_t;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int MEM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic [WORD_W-1:0] store_q [MEM_DEPTH];
  logic [IDX_W-1:0]  idx;

  // Fold the full address field onto the array
  assign idx   = IDX_W'(addr % ADDR_W'(MEM_DEPTH));
  assign rdata = store_q[idx];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[idx] <= wdata;
    end
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output xfer_t            xfer,
  output logic             halted
);
  step_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH_ADDR: state_d = ST_FETCH_WAIT;
      ST_FETCH_WAIT: state_d = ST_DECODE;
      ST_DECODE:     state_d = ST_OPER_ADDR;
      ST_OPER_ADDR:  state_d = (opcode == OP_HALT) ? ST_HALT : ST_OPER_WAIT;
      ST_OPER_WAIT:  state_d = ST_EXEC;
      ST_EXEC:       state_d = ST_INCR;
      ST_INCR:       state_d = ST_FETCH_ADDR;
      ST_HALT:       state_d = ST_HALT;
      default:       state_d = ST_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH_ADDR;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    xfer = '0;
    unique case (state_q)
      ST_FETCH_ADDR: xfer.mar_from_pc  = 1'b1;
      ST_FETCH_WAIT: xfer.mdr_from_mem = 1'b1;
      ST_DECODE:     xfer.ir_load      = 1'b1;
      ST_OPER_ADDR:  xfer.mar_from_ir  = (opcode != OP_HALT);
      ST_OPER_WAIT:  xfer.mdr_from_mem = 1'b1;
      ST_EXEC: begin
        unique case (opcode)
          OP_LOAD:  xfer.acc_load = 1'b1;
          OP_ADD:   xfer.acc_add  = 1'b1;
          OP_STORE: begin
            xfer.mdr_from_acc = 1'b1;
            xfer.mem_we       = 1'b1;
          end
          default: ;
        endcase
      end
      ST_INCR:       xfer.pc_inc = 1'b1;
      default: ;
    endcase
  end

  assign halted = (state_q == ST_HALT);

  // R1
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH_WAIT) |-> ($past(state_q) == ST_FETCH_ADDR));

  // R1
  incr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INCR) |-> ($past(state_q) == ST_EXEC));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_t             xfer,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] acc
);
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [WORD_W-1:0] mdr_q, mdr_d, ir_q, ir_d, acc_q, acc_d;
  logic              pc_en, mar_en, mdr_en, ir_en, acc_en;

  always_comb begin
    pc_en  = xfer.pc_inc;
    pc_d   = pc_q + ADDR_W'(1);

    mar_en = xfer.mar_from_pc | xfer.mar_from_ir;
    mar_d  = xfer.mar_from_pc ? pc_q : ir_q[ADDR_W-1:0];

    mdr_en = xfer.mdr_from_mem | xfer.mdr_from_acc;
    mdr_d  = xfer.mdr_from_acc ? acc_q : mem_rdata;

    ir_en  = xfer.ir_load;
    ir_d   = mdr_q;

    acc_en = xfer.acc_load | xfer.acc_add;
    acc_d  = xfer.acc_add ? (acc_q + mdr_q) : mdr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign opcode    = ir_q[WORD_W-1 -: OPC_W];
  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R7
  acc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> $past(xfer.acc_load || xfer.acc_add));
endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
  import acc_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MEM_DEPTH = 256,
  localparam int ADDR_W   = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_out,
  output logic [WORD_W-1:0] acc_out
);
  logic [1:0]        rst_pipe_q;
  logic              core_rst_n;
  xfer_t             xfer;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] cpu_addr, mem_addr;
  logic [WORD_W-1:0] cpu_wdata, mem_wdata, mem_rdata;
  logic              mem_we;

  // Assert asynchronously, release on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  // Host owns the single memory port whenever it asks
  always_comb begin
    mem_we    = host_en ? host_we    : xfer.mem_we;
    mem_addr  = host_en ? host_addr  : cpu_addr;
    mem_wdata = host_en ? host_wdata : cpu_wdata;
  end

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .opcode (opcode),
    .xfer   (xfer),
    .halted (halted)
  );

  acc_datapath #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .opcode    (opcode),
    .mem_addr  (cpu_addr),
    .mem_wdata (cpu_wdata),
    .pc        (pc_out),
    .acc       (acc_out)
  );

  acc_mem #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign host_rdata = mem_rdata;
endmodule

// File: tb/acc_seq_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_seq_cpu_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_en, host_we;
  logic [11:0] host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        halted;
  logic [11:0] pc_out;
  logic [15:0] acc_out;

  int n_checks = 0;
  int n_fails  = 0;

  logic [15:0] img     [DEPTH];
  logic [15:0] ref_mem [DEPTH];
  int          exp_acc, exp_pc, exp_steps;

  always #2.5 clk = ~clk;

  acc_seq_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .halted(halted), .pc_out(pc_out), .acc_out(acc_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Interpret the image by the requirements
  task automatic model();
    int pc;
    logic [15:0] a;
    logic [15:0] w;
    int idx;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = img[i];
    pc = 0; a = 16'h0; exp_steps = 0;
    while (pc < DEPTH) begin
      w = ref_mem[pc];
      if (w[15:12] == 4'hF) break;
      idx = int'(w[11:0]) % DEPTH;
      case (w[15:12])
        4'h0: a = ref_mem[idx];
        4'h1: ref_mem[idx] = a;
        4'h2: a = a + ref_mem[idx];
        default: ;
      endcase
      pc++;
      exp_steps++;
    end
    exp_acc = int'(a);
    exp_pc  = pc;
  endtask

  task automatic run_one(input string name);
    int cycles;
    int bad_idx;
    logic [15:0] hold_acc;
    logic [11:0] hold_pc;
    model();
    @(negedge clk);
    rst_n = 1'b0;
    host_en = 1'b1;
    host_we = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      host_addr  = 12'(i);
      host_wdata = img[i];
      @(negedge clk);
    end
    host_we = 1'b0;
    host_en = 1'b0;
    // R8 reset state
    check(pc_out == 12'h0 && acc_out == 16'h0 && !halted, {"R8 reset ", name},
          {pc_out, acc_out, 3'b0, halted}, 0);
    rst_n = 1'b1;
    cycles = 0;
    while (cycles < 4000) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (halted) break;
    end
    if (!halted) begin
      check(1'b0, {"R6 halt timeout ", name}, 0, 1);
      return;
    end
    // R1 cycle count 7n+6
    check(cycles == 7 * exp_steps + 6, {"R1 timing ", name}, cycles, 7 * exp_steps + 6);
    // R3 R5 final accumulator
    check(int'(acc_out) == exp_acc, {"R3/R5 acc ", name}, int'(acc_out), exp_acc);
    // R10 PC parked on halt word
    check(int'(pc_out) == exp_pc, {"R10 pc ", name}, int'(pc_out), exp_pc);
    hold_acc = acc_out;
    hold_pc  = pc_out;
    repeat (12) @(negedge clk);
    // R6 state frozen after halt
    check(halted && acc_out == hold_acc && pc_out == hold_pc, {"R6 freeze ", name},
          int'(acc_out), int'(hold_acc));
    // R4 R9 memory contents through host port
    host_en = 1'b1;
    bad_idx = -1;
    for (int i = 0; i < DEPTH; i++) begin
      host_addr = 12'(i) | 12'h700;
      #1;
      if (host_rdata != ref_mem[i] && bad_idx < 0) bad_idx = i;
    end
    @(negedge clk);
    host_en = 1'b0;
    if (bad_idx >= 0) begin
      host_addr = 12'(bad_idx);
      host_en = 1'b1;
      #1;
      check(1'b0, {"R4 memory ", name}, int'(host_rdata), int'(ref_mem[bad_idx]));
      host_en = 1'b0;
    end else begin
      check(1'b1, {"R4 memory ", name}, 0, 0);
    end
  endtask

  task automatic clear_image();
    for (int i = 0; i < DEPTH; i++) img[i] = 16'h0;
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  initial begin
    rst_n = 1'b0; host_en = 1'b0; host_we = 1'b0;
    host_addr = '0; host_wdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);

    // Directed: wrap-around add, folded address fields (R2, R5)
    clear_image();
    img[128] = 16'hFFFF; img[129] = 16'h0002;
    img[0] = ins(4'h0, 12'hA80);
    img[1] = ins(4'h2, 12'h381);
    img[2] = ins(4'h1, 12'hF82);
    img[3] = ins(4'hF, 12'h000);
    run_one("wrap_add");
    check(exp_acc == 1, "R5 wrap model", exp_acc, 1);

    // Directed: store then reload (R3, R4)
    clear_image();
    img[128] = 16'h1234;
    img[0] = ins(4'h0, 12'h080);
    img[1] = ins(4'h1, 12'h083);
    img[2] = ins(4'h0, 12'h084);
    img[3] = ins(4'h0, 12'h183);
    img[4] = ins(4'hF, 12'h000);
    run_one("store_reload");

    // Directed: ignored opcodes (R7)
    clear_image();
    img[128] = 16'h00AA; img[133] = 16'h5555;
    img[0] = ins(4'h0, 12'h080);
    img[1] = ins(4'h5, 12'h080);
    img[2] = ins(4'h7, 12'h085);
    img[3] = ins(4'hE, 12'h085);
    img[4] = ins(4'hF, 12'h000);
    run_one("ignored_ops");
    check(exp_acc == 16'h00AA, "R7 model", exp_acc, 16'h00AA);

    // Directed: halt at word 0 (R6)
    clear_image();
    img[0] = ins(4'hF, 12'h123);
    run_one("halt_first");

    // Random programs
    for (int t = 0; t < 24; t++) begin
      int n;
      n = 5 + int'($urandom % 30);
      clear_image();
      for (int i = 128; i < DEPTH; i++) img[i] = 16'($urandom);
      for (int i = 0; i < n; i++) begin
        int r;
        logic [3:0] op;
        r = int'($urandom % 16);
        if (r < 5)       op = 4'h0;
        else if (r < 10) op = 4'h2;
        else if (r < 14) op = 4'h1;
        else             op = 4'h5 + 4'(r & 1);
        img[i] = {op, 4'($urandom), 1'b1, 7'($urandom)};
      end
      img[n] = {4'hF, 12'($urandom)};
      run_one($sformatf("rand%0d", t));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule